// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits beside one processor core and lets software build atomic read-modify-write loops from a pair of instructions. A load-exclusive opens a reservation on one word. A later store-exclusive to the same word writes memory only if nothing else has stored to that word in the meantime. It reports the outcome to the core as the value 1 on success and 0 on failure, so a loop can retry.

The monitor holds one entry, made of a word tag, a valid bit and an exclusive flag. Any store to the reserved word clears the flag. That store may come from this core, through the request port, or from another core, through one of `N_SNOOP` snoop ports. Exclusive operations carry no ordering semantics. The monitor never stalls, drains or waits for earlier accesses.

Requests carry a `req_valid` qualifier but no ready. The monitor accepts one request on every cycle, so there is no back-pressure. Snoop ports are qualified in the same way. The memory write port and the result port are registered valid-qualified outputs, one cycle after the request. Memory is assumed to accept every write, so neither output port has a ready.

Top module: `xmon`

## Requirements
- R1: A request with `req_op`=0 (load-exclusive) makes the entry valid, stores the word of its address as the tag and sets the flag to 1. It drives neither `wr_valid` nor `res_valid`.
- R2: A request with `req_op`=1 (store-exclusive) succeeds when the entry is valid, the flag is 1 and the request word equals the tag. One cycle later, `wr_valid`=1 with the computed address and the request data, and `res_valid`=1 with `res_data`=1.
- R3: A store-exclusive that does not succeed has `res_valid`=1 and `res_data`=0 one cycle later, and `wr_valid`=0.
- R4: After reset the entry is invalid, so a store-exclusive issued before any load-exclusive fails.
- R5: The effective address is `req_base` plus `req_offset`. The offset is sign-extended when `OFFSET_SIGNED`=1, and the sum wraps modulo 2^AW.
- R6: A request with `req_op`=2 (ordinary store) writes memory one cycle later, with no result. If its word equals the tag, it clears the flag.
- R7: A valid snoop whose word equals the tag clears the flag. A snoop to any other word leaves the entry unchanged.
- R8: A valid snoop that targets the request word in the same cycle wins over the request. A store-exclusive then fails, and a load-exclusive records its entry with the flag at 0.
- R9: A new load-exclusive replaces any existing entry.
- R10: Every store-exclusive, whether it succeeds or fails, invalidates the entry.
- R11: Words are compared with address bits [1:0] ignored, for both local requests and snoops.
- R12: A store-exclusive whose word differs from the tag fails, even when the flag is 1.
- R13: A request is accepted on every cycle with no stall. `req_op`=3 and cycles with `req_valid`=0 produce no output and do not change the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request qualifier |
| req_op | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 store, 3 none |
| req_base | input | AW | Base register value |
| req_offset | input | OW | Immediate offset |
| req_wdata | input | DW | Store data |
| snoop_valid | input | N_SNOOP | Per-port snoop qualifier |
| snoop_addr | input | N_SNOOP*AW | Snooped store addresses, port i in bits [i*AW +: AW] |
| wr_valid | output | 1 | Memory write enable |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DW | Memory write data |
| res_valid | output | 1 | Store-exclusive result qualifier |
| res_data | output | DW | Store-exclusive result, 1 or 0 |

## Verification
Two things can land on the same clock edge: a snooped store from another core, and a local load-exclusive or store-exclusive to the same word. The bench provokes this by driving a snoop in the very cycle of the exclusive request, as well as one cycle earlier. It sweeps each case over many reserved addresses and over every byte offset within and beyond the word. A reference model in the bench applies the snoop before the local operation. A same-cycle collision must therefore give a failed store-exclusive with no memory write, or a reservation that fails on its next use.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  typedef enum logic [1:0] {
    OP_LDEX  = 2'd0,
    OP_STEX  = 2'd1,
    OP_STORE = 2'd2,
    OP_NONE  = 2'd3
  } xmon_op_e;
endpackage

// File: rtl/xmon_agen.sv
// Effective address: base plus an immediate, sign- or zero-extended by parameter.
module xmon_agen #(
  parameter int AW            = 32,
  parameter int OW            = 12,
  parameter bit OFFSET_SIGNED = 1'b1
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offset,
  output logic [AW-1:0] addr,
  output logic [AW-3:0] word
);
  localparam int EXT = AW - OW;
  logic [AW-1:0] off_ext;

  generate
    if (OFFSET_SIGNED) begin : g_sext
      assign off_ext = {{EXT{offset[OW-1]}}, offset};
    end else begin : g_zext
      assign off_ext = {{EXT{1'b0}}, offset};
    end
  endgenerate

  assign addr = base + off_ext;
  assign word = addr[AW-1:2];
endmodule

// File: rtl/xmon_snoop.sv
// Compares every snoop port against the held tag and the request word.
module xmon_snoop #(
  parameter int AW      = 32,
  parameter int N_SNOOP = 2
) (
  input  logic [N_SNOOP-1:0]    snoop_valid,
  input  logic [N_SNOOP*AW-1:0] snoop_addr,
  input  logic [AW-3:0]         tag,
  input  logic [AW-3:0]         req_word,
  output logic                  hit_tag,
  output logic                  hit_req
);
  logic [N_SNOOP-1:0] m_tag;
  logic [N_SNOOP-1:0] m_req;
  logic [N_SNOOP-1:0] unused_low;

  generate
    for (genvar i = 0; i < N_SNOOP; i++) begin : g_port
      logic [AW-3:0] sw;
      assign sw         = snoop_addr[i*AW+2 +: AW-2];
      assign unused_low[i] = ^snoop_addr[i*AW +: 2];
      assign m_tag[i]   = snoop_valid[i] && (sw == tag);
      assign m_req[i]   = snoop_valid[i] && (sw == req_word);
    end
  endgenerate

  assign hit_tag = |m_tag;
  assign hit_req = |m_req;
endmodule

// File: rtl/xmon_entry.sv
// The single reservation: valid bit, word tag and exclusive flag.
module xmon_entry
  import xmon_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  xmon_op_e      op,
  input  logic [AW-3:0] req_word,
  input  logic          snp_hit_tag,
  input  logic          snp_hit_req,
  output logic [AW-3:0] tag,
  output logic          stex_ok
);
  logic ent_valid;
  logic ent_flag;
  logic tag_match;

  assign tag_match = (req_word == tag);
  assign stex_ok   = ent_valid && ent_flag && tag_match && !snp_hit_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
      ent_flag  <= 1'b0;
      tag       <= '0;
    end else begin
      if (snp_hit_tag) ent_flag <= 1'b0;
      if (req_valid) begin
        unique case (op)
          OP_LDEX: begin
            ent_valid <= 1'b1;
            tag       <= req_word;
            ent_flag  <= !snp_hit_req;
          end
          OP_STEX: begin
            ent_valid <= 1'b0;
            ent_flag  <= 1'b0;
          end
          OP_STORE: begin
            if (tag_match) ent_flag <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xmon_outreg.sv
// Registered memory write port and store-exclusive result.
module xmon_outreg
  import xmon_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  xmon_op_e      op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          stex_ok,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  logic do_write;
  logic do_result;

  assign do_result = req_valid && (op == OP_STEX);
  assign do_write  = req_valid && ((op == OP_STORE) || (do_result && stex_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      wr_valid  <= do_write;
      wr_addr   <= do_write ? addr : '0;
      wr_data   <= do_write ? wdata : '0;
      res_valid <= do_result;
      res_data  <= (do_result && stex_ok) ? DW'(1) : '0;
    end
  end
endmodule

// File: rtl/xmon.sv
module xmon
  import xmon_pkg::*;
#(
  parameter int AW            = 32,
  parameter int DW            = 32,
  parameter int OW            = 12,
  parameter int N_SNOOP       = 2,
  parameter bit OFFSET_SIGNED = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [AW-1:0]         req_base,
  input  logic [OW-1:0]         req_offset,
  input  logic [DW-1:0]         req_wdata,
  input  logic [N_SNOOP-1:0]    snoop_valid,
  input  logic [N_SNOOP*AW-1:0] snoop_addr,
  output logic                  wr_valid,
  output logic [AW-1:0]         wr_addr,
  output logic [DW-1:0]         wr_data,
  output logic                  res_valid,
  output logic [DW-1:0]         res_data
);
  xmon_op_e      op;
  logic [AW-1:0] addr;
  logic [AW-3:0] word;
  logic [AW-3:0] tag;
  logic          hit_tag;
  logic          hit_req;
  logic          stex_ok;

  assign op = xmon_op_e'(req_op);

  xmon_agen #(.AW(AW), .OW(OW), .OFFSET_SIGNED(OFFSET_SIGNED)) u_agen (
    .base(req_base), .offset(req_offset), .addr(addr), .word(word)
  );

  xmon_snoop #(.AW(AW), .N_SNOOP(N_SNOOP)) u_snoop (
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .tag(tag),
    .req_word(word), .hit_tag(hit_tag), .hit_req(hit_req)
  );

  xmon_entry #(.AW(AW)) u_entry (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .req_word(word),
    .snp_hit_tag(hit_tag), .snp_hit_req(hit_req), .tag(tag), .stex_ok(stex_ok)
  );

  xmon_outreg #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .addr(addr),
    .wdata(req_wdata), .stex_ok(stex_ok), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .res_valid(res_valid), .res_data(res_data)
  );
endmodule

// File: rtl/xmon_checker.sv
module xmon_checker #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int OW      = 12,
  parameter int N_SNOOP = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [1:0]            req_op,
  input logic [AW-1:0]         req_base,
  input logic [OW-1:0]         req_offset,
  input logic [DW-1:0]         req_wdata,
  input logic [N_SNOOP-1:0]    snoop_valid,
  input logic [N_SNOOP*AW-1:0] snoop_addr,
  input logic                  wr_valid,
  input logic [AW-1:0]         wr_addr,
  input logic [DW-1:0]         wr_data,
  input logic                  res_valid,
  input logic [DW-1:0]         res_data
);
  logic [AW-1:0] c_addr;
  logic          c_same;
  logic          seen_ldex;
  logic          last_was_stex;

  assign c_addr = req_base + {{(AW-OW){req_offset[OW-1]}}, req_offset};

  always_comb begin
    c_same = 1'b0;
    for (int i = 0; i < N_SNOOP; i++)
      if (snoop_valid[i] && (snoop_addr[i*AW+2 +: AW-2] == c_addr[AW-1:2])) c_same = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_ldex     <= 1'b0;
      last_was_stex <= 1'b0;
    end else if (req_valid && req_op == 2'd0) begin
      seen_ldex     <= 1'b1;
      last_was_stex <= 1'b0;
    end else if (req_valid && req_op == 2'd1) begin
      last_was_stex <= 1'b1;
    end
  end

  p_ldex_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd0 |=> !wr_valid && !res_valid);
  p_stex_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 |=> res_valid);
  p_fail_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_data == '0 |-> !wr_valid);
  p_result_binary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data <= DW'(1));
  p_no_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 && !seen_ldex |=> res_data == '0);
  p_store_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd2 |=> wr_valid && !res_valid && wr_data == $past(req_wdata));
  p_snoop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 && c_same |=> res_valid && res_data == '0 && !wr_valid);
  p_consumed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 && last_was_stex |=> res_data == '0 && !wr_valid);
  p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid || req_op == 2'd3 |=> !wr_valid && !res_valid);
endmodule

bind xmon xmon_checker #(.AW(AW), .DW(DW), .OW(OW), .N_SNOOP(N_SNOOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
  .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_data(wr_data), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/xmon_bench.sv
module xmon_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int OW = 4;
  localparam int NS = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [1:0]      req_op = 2'd3;
  logic [AW-1:0]   req_base = '0;
  logic [OW-1:0]   req_offset = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic [NS-1:0]   snoop_valid = '0;
  logic [NS*AW-1:0] snoop_addr = '0;
  logic            wr_valid;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data;
  logic            res_valid;
  logic [DW-1:0]   res_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference entry
  bit            mv = 1'b0;
  bit            mf = 1'b0;
  logic [AW-3:0] mtag = '0;

  always #5 clk = ~clk;

  xmon #(.AW(AW), .DW(DW), .OW(OW), .N_SNOOP(NS), .OFFSET_SIGNED(1'b1)) u_xmon (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check_out(input string tag, input bit ewv, input logic [AW-1:0] ewa,
                           input logic [DW-1:0] ewd, input bit erv, input logic [DW-1:0] erd);
    bit ok;
    ok = (wr_valid == ewv) && (res_valid == erv) && (!ewv || (wr_addr == ewa && wr_data == ewd))
         && (!erv || res_data == erd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got wv=%0b wa=%0h wd=%0h rv=%0b rd=%0h exp wv=%0b wa=%0h wd=%0h rv=%0b rd=%0h",
               tag, wr_valid, wr_addr, wr_data, res_valid, res_data, ewv, ewa, ewd, erv, erd);
    end
  endtask

  // One request (plus snoops) in one cycle; outputs checked just after the edge.
  task automatic step(input logic [1:0] op, input logic [AW-1:0] base, input logic [OW-1:0] off,
                      input logic [DW-1:0] d, input logic [NS-1:0] sv,
                      input logic [AW-1:0] s0, input logic [AW-1:0] s1, input string tag);
    logic [AW-1:0] a;
    logic [AW-3:0] w;
    bit sh_req, sh_tag, ok, ewv, erv;
    a = base + AW'($signed(off));
    w = a[AW-1:2];
    sh_req = (sv[0] && s0[AW-1:2] == w) || (sv[1] && s1[AW-1:2] == w);
    sh_tag = (sv[0] && s0[AW-1:2] == mtag) || (sv[1] && s1[AW-1:2] == mtag);
    ok  = (op == 2'd1) && mv && mf && (w == mtag) && !sh_req;
    ewv = (op == 2'd2) || ok;
    erv = (op == 2'd1);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_wdata = d;
    snoop_valid = sv; snoop_addr = {s1, s0};
    @(posedge clk);
    #1;
    req_valid = 1'b0; snoop_valid = '0;
    if (sh_tag) mf = 1'b0;
    case (op)
      2'd0: begin mv = 1'b1; mtag = w; mf = !sh_req; end
      2'd1: begin mv = 1'b0; mf = 1'b0; end
      2'd2: if (w == mtag) mf = 1'b0;
      default: ;
    endcase
    check_out(tag, ewv, a, d, erv, ok ? DW'(1) : DW'(0));
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = '0;
    @(posedge clk);
    #1;
    check_out(tag, 1'b0, '0, '0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_out("R4 reset state", 1'b0, '0, '0, 1'b0, '0);

    // R4: store-exclusive before any load-exclusive fails
    step(2'd1, 8'h40, 4'h0, 8'h11, 2'b00, '0, '0, "R4 no entry");
    // R5: negative offset wraps below zero
    step(2'd0, 8'h02, 4'hC, 8'h00, 2'b00, '0, '0, "R1 ldex wrap");
    step(2'd1, 8'h02, 4'hC, 8'h5A, 2'b00, '0, '0, "R5 R2 stex wrap");
    // R10: entry is consumed by a successful store-exclusive
    step(2'd1, 8'h02, 4'hC, 8'h5B, 2'b00, '0, '0, "R10 second stex");
    // R9: second load-exclusive replaces the first
    step(2'd0, 8'h10, 4'h0, 8'h00, 2'b00, '0, '0, "R1 ldex A");
    step(2'd0, 8'h20, 4'h0, 8'h00, 2'b00, '0, '0, "R9 ldex B");
    step(2'd1, 8'h10, 4'h0, 8'h21, 2'b00, '0, '0, "R9 stex old");
    step(2'd0, 8'h10, 4'h0, 8'h00, 2'b00, '0, '0, "R1 ldex A");
    step(2'd0, 8'h20, 4'h0, 8'h00, 2'b00, '0, '0, "R9 ldex B");
    step(2'd1, 8'h20, 4'h0, 8'h22, 2'b00, '0, '0, "R9 stex new");
    // R8: snoop in the load-exclusive cycle spoils the new entry
    step(2'd0, 8'h30, 4'h0, 8'h00, 2'b10, 8'h00, 8'h33, "R8 ldex with snoop");
    step(2'd1, 8'h30, 4'h0, 8'h23, 2'b00, '0, '0, "R8 stex after");
    // R13: none-op and idle cycles leave the entry alone
    step(2'd0, 8'h50, 4'h0, 8'h00, 2'b00, '0, '0, "R1 ldex");
    step(2'd3, 8'h50, 4'h0, 8'h77, 2'b00, '0, '0, "R13 none op");
    idle("R13 idle");
    step(2'd1, 8'h50, 4'h0, 8'h24, 2'b00, '0, '0, "R13 stex after none");
    // R10: failed store-exclusive also consumes the entry
    step(2'd0, 8'h60, 4'h0, 8'h00, 2'b00, '0, '0, "R1 ldex");
    step(2'd1, 8'h64, 4'h0, 8'h25, 2'b00, '0, '0, "R12 mismatch");
    step(2'd1, 8'h60, 4'h0, 8'h26, 2'b00, '0, '0, "R10 after failed");

    // sweep: reserved address, stex byte distance, intervening event
    for (int la = 0; la < 256; la += 3) begin
      for (int dl = 0; dl < 8; dl++) begin
        for (int md = 0; md < 5; md++) begin
          logic [OW-1:0] off;
          logic [AW-1:0] lav, sav, sb, lb;
          bit same;
          string tg;
          off = OW'((la * 5 + dl) % 16);
          lav = AW'(la);
          sav = AW'(la + dl);
          lb  = lav - AW'($signed(off));
          sb  = sav - AW'($signed(off));
          same = (lav[AW-1:2] == sav[AW-1:2]);
          step(2'd0, lb, off, 8'h00, 2'b00, '0, '0, "R1 sweep ldex");
          case (md)
            0: idle("R13 sweep gap");
            1: step(2'd3, 8'h00, 4'h0, 8'h00, 2'b01, lav ^ 8'h03, '0, "R7 snoop hit");
            2: step(2'd3, 8'h00, 4'h0, 8'h00, 2'b10, '0, lav + 8'h04, "R7 snoop miss");
            3: step(2'd2, lav ^ 8'h01, 4'h0, 8'hA5, 2'b00, '0, '0, "R6 local store");
            default: idle("R13 sweep gap");
          endcase
          if (md == 4) tg = "R8 same-cycle snoop";
          else if (md == 3) tg = "R6 stex after store";
          else if (md == 1 || md == 2) tg = "R7 stex after snoop";
          else if (!same) tg = "R12 stex other word";
          else if (dl != 0) tg = "R11 stex low bits";
          else tg = "R2 stex match";
          if (md == 4)
            step(2'd1, sb, off, DW'(la + dl), 2'b01, {lav[AW-1:2], 2'b10}, '0, tg);
          else
            step(2'd1, sb, off, DW'(la + dl), 2'b00, '0, '0, tg);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule